// File: doc/BRIEF.md
# JTAG Device Identifier Reader

This block is a host-side JTAG master. It reads the identification word of an unknown target without loading any instruction. After a start pulse it drives TCK, TMS and TDI onto the pins under test. It forces the target's TAP controller into Test-Logic-Reset by holding TMS high, then steers the TAP into Shift-DR and clocks 32 bits out of TDO. After a TAP reset the data path of a compliant device holds its 32-bit identifier, or the single-bit bypass register if the device has no identifier. The captured word is therefore enough to tell an identifier, a bypass-only device and a dead pin apart.

TCK comes from the system clock through a programmable divider, and the shortest allowed half-period is one system clock. TMS changes only while TCK is low, and TDO is sampled at the system clock edge on which TCK rises. The result leaves through a valid/ready output. A word and its classification stay on the port until the consumer accepts them with `res_ready`. While a result waits, no new read can begin, so back-pressure stalls the next start and no word is ever lost or overwritten. `busy` is a plain status pin.

The classification follows the least significant bit. A 1 marks an identifier and a 0 marks a default bypass register. A word of all ones or all zeros is reported as a stuck or floating TDO instead.

Top module: `jtag_idcode_reader`

## Requirements
- R1: Out of reset, `tck` is 0, `tms` is 1, `busy` is 0 and `res_valid` is 0.
- R2: A `start` pulse is accepted only when `busy` and `res_valid` are both 0, and `busy` is 1 in the following cycle. A `start` given while busy or while a result waits has no effect: the run in progress keeps its count of 41 TCK rising edges, and a waiting result stays unchanged.
- R3: While busy, every high phase and every low phase of `tck` lasts `tck_half_m1`+1 system clocks. When not busy, `tck` rests at 0.
- R4: `tms` changes only in cycles where `tck` is 0, and `tdi` is held at the constant level given by the `TDI_LEVEL` parameter (default 1).
- R5: Each run makes exactly 41 TCK rising edges. The TMS values seen at those edges are: 1 at edges 0-4, then 0, 1, 0, 0 at edges 5-8, then 0 at edges 9-39, and 1 at edge 40 (edges numbered from 0).
- R6: TDO is sampled at rising edges 9 to 40. The value sampled at edge 9+i becomes bit i of `res_word`, so the first bit out is the least significant.
- R7: `res_is_id` is 1 exactly when bit 0 of the word is 1 and the word is not all ones.
- R8: `res_bypass` is 1 exactly when bit 0 of the word is 0 and the word is not all zeros.
- R9: `res_stuck` is 1 exactly when the word is all zeros or all ones. While `res_valid` is 1, exactly one of the three flags is 1.
- R10: `res_valid` rises in the same cycle that `busy` falls. `res_word` and the flags then hold steady until a cycle with `res_ready` 1, after which `res_valid` is 0.
- R11: The read succeeds whatever state the target TAP was in before the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tck_half_m1 | input | DIV_W | TCK half-period in system clocks, minus one; held steady during a run |
| start | input | 1 | Start request, sampled each cycle |
| busy | output | 1 | A read is in progress |
| tck | output | 1 | Test clock to target |
| tms | output | 1 | Test mode select to target |
| tdi | output | 1 | Test data to target, held constant |
| tdo | input | 1 | Test data from target |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts result |
| res_word | output | 32 | Captured word, first bit received in bit 0 |
| res_is_id | output | 1 | Word is a plausible identifier |
| res_bypass | output | 1 | Word came from a bypass register |
| res_stuck | output | 1 | TDO looked stuck or floating |

## Verification
An edge counter that is off by one shows up directly at the ports. The TMS value seen at a rising edge shifts, the total rise count moves away from 41, and the captured word shifts or picks up a bypass bit. All of this is visible at the end of the first run. A divider fault shows on the first TCK phase after start. A bit-order fault shows as a reversed word as soon as a non-palindromic identifier is read. A fault in the output hold shows within a cycle of withholding `res_ready`. A classifier fault shows on the first word of each pattern class: identifier, all ones, bypass, or all zeros.

// File: rtl/jid_pkg.sv
package jid_pkg;
  localparam int unsigned ID_W        = 32;
  localparam int unsigned RST_EDGES   = 5;
  localparam int unsigned NAV_EDGES   = 4;
  localparam int unsigned SHIFT_FIRST = RST_EDGES + NAV_EDGES;
  localparam int unsigned TOTAL_EDGES = SHIFT_FIRST + ID_W;
  localparam int unsigned EDGE_W      = $clog2(TOTAL_EDGES + 1);

  typedef logic [EDGE_W-1:0] edge_t;

  typedef struct packed {
    logic is_id;
    logic bypass;
    logic stuck;
  } verdict_t;

  // TMS level to present for rising edge number k of a run
  function automatic logic tms_at(edge_t k);
    if (k < edge_t'(RST_EDGES)) return 1'b1;
    if (k < edge_t'(SHIFT_FIRST)) return (k == edge_t'(RST_EDGES + 1));
    if (k == edge_t'(TOTAL_EDGES - 1)) return 1'b1;
    return 1'b0;
  endfunction
endpackage

// File: rtl/jid_tck_gen.sv
module jid_tck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_m1,
  output logic             tck,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap    = run && (cnt == half_m1);
  assign rise_ev = wrap && !tck;
  assign fall_ev = wrap && tck;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      tck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      tck <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      tck <= ~tck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3
  tck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tck);

  // R3
  tck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> (tck == $past(tck)));
endmodule

// File: rtl/jid_seq.sv
module jid_seq
  import jid_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            hold,
  input  logic            tdo,
  input  logic            rise_ev,
  input  logic            fall_ev,
  output logic            busy,
  output logic            tms,
  output logic            done,
  output logic [ID_W-1:0] word
);
  edge_t eidx;
  logic  launch;

  assign launch = start && !busy && !hold;
  assign done   = busy && fall_ev && (eidx == edge_t'(TOTAL_EDGES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      eidx <= '0;
      tms  <= 1'b1;
      word <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      eidx <= '0;
      tms  <= tms_at('0);
    end else if (busy) begin
      if (rise_ev) begin
        eidx <= eidx + 1'b1;
        if (eidx >= edge_t'(SHIFT_FIRST))
          word <= {tdo, word[ID_W-1:1]};
      end
      if (fall_ev) begin
        if (eidx == edge_t'(TOTAL_EDGES)) busy <= 1'b0;
        else tms <= tms_at(eidx);
      end
    end
  end

  // R5
  edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (eidx <= edge_t'(TOTAL_EDGES)));

  // R2
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && eidx >= $past(eidx)));

  // R5
  exit_tms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> tms);
endmodule

// File: rtl/jid_classify.sv
module jid_classify
  import jid_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [ID_W-1:0] word_in,
  input  logic            ready,
  output logic            valid,
  output logic [ID_W-1:0] word,
  output verdict_t        verdict
);
  logic     all1, all0;
  verdict_t vnext;

  assign all1 = &word_in;
  assign all0 = ~|word_in;

  always_comb begin
    vnext.stuck  = all1 | all0;
    vnext.is_id  = word_in[0] & ~all1;
    vnext.bypass = ~word_in[0] & ~all0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      word    <= '0;
      verdict <= '0;
    end else if (load) begin
      valid   <= 1'b1;
      word    <= word_in;
      verdict <= vnext;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> (valid && $stable(word) && $stable(verdict)));

  // R9
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($countones(verdict) == 1));

  // R7
  id_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && verdict.is_id) |-> word[0]);

  // R8
  bypass_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && verdict.bypass) |-> !word[0]);
endmodule

// File: rtl/jtag_idcode_reader.sv
module jtag_idcode_reader
  import jid_pkg::*;
#(
  parameter int   DIV_W     = 8,
  parameter logic TDI_LEVEL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] tck_half_m1,
  input  logic             start,
  output logic             busy,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  input  logic             tdo,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [ID_W-1:0]  res_word,
  output logic             res_is_id,
  output logic             res_bypass,
  output logic             res_stuck
);
  logic            rise_ev, fall_ev, done;
  logic [ID_W-1:0] shift_word;
  verdict_t        verdict;

  assign tdi = TDI_LEVEL;

  jid_tck_gen #(.DIV_W(DIV_W)) u_tck (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .half_m1 (tck_half_m1),
    .tck     (tck),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  jid_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .hold    (res_valid),
    .tdo     (tdo),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .busy    (busy),
    .tms     (tms),
    .done    (done),
    .word    (shift_word)
  );

  jid_classify u_cls (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (done),
    .word_in (shift_word),
    .ready   (res_ready),
    .valid   (res_valid),
    .word    (res_word),
    .verdict (verdict)
  );

  assign res_is_id  = verdict.is_id;
  assign res_bypass = verdict.bypass;
  assign res_stuck  = verdict.stuck;

  // R4
  tms_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tck && $past(tck)) |-> $stable(tms));

  // R10
  busy_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && res_valid));

  // R10
  handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> res_valid);
endmodule

// File: tb/jtag_idcode_reader_bench.sv
`timescale 1ns/1ps
module jtag_idcode_reader_bench;
  typedef enum logic [3:0] {TLR, RTI, SDS, CDR, SHD, E1D, PDR, E2D, UDR,
                            SIS, CIR, SHI, E1I, PIR, E2I, UIR} tap_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  half = 8'd0;
  logic        start = 1'b0;
  logic        res_ready = 1'b0;
  logic        busy, tck, tms, tdi, tdo, res_valid;
  logic [31:0] res_word;
  logic        res_is_id, res_bypass, res_stuck;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  jtag_idcode_reader u_jtag_idcode_reader (
    .clk(clk), .rst_n(rst_n), .tck_half_m1(half), .start(start), .busy(busy),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .res_valid(res_valid),
    .res_ready(res_ready), .res_word(res_word), .res_is_id(res_is_id),
    .res_bypass(res_bypass), .res_stuck(res_stuck));

  // target TAP model
  tap_t        ts = TLR;
  logic [31:0] dev_id = 32'h0;
  logic        has_id = 1'b1;
  logic [31:0] dr = 32'h0;
  logic        bp = 1'b0;
  logic        tdo_model = 1'b1;
  logic        force_en = 1'b0;
  logic        force_val = 1'b0;
  int          rise_n = 0;
  logic        tms_log [0:63];

  function automatic tap_t nxt(tap_t s, logic m);
    case (s)
      TLR: return m ? TLR : RTI;
      RTI: return m ? SDS : RTI;
      SDS: return m ? SIS : CDR;
      CDR: return m ? E1D : SHD;
      SHD: return m ? E1D : SHD;
      E1D: return m ? UDR : PDR;
      PDR: return m ? E2D : PDR;
      E2D: return m ? UDR : SHD;
      UDR: return m ? SDS : RTI;
      SIS: return m ? TLR : CIR;
      CIR: return m ? E1I : SHI;
      SHI: return m ? E1I : SHI;
      E1I: return m ? UIR : PIR;
      PIR: return m ? E2I : PIR;
      E2I: return m ? UIR : SHI;
      default: return m ? SDS : RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    if (ts == CDR) begin
      dr = dev_id;
      bp = 1'b0;
    end else if (ts == SHD) begin
      dr = {tdi, dr[31:1]};
      bp = tdi;
    end
    if (rise_n < 64) tms_log[rise_n] = tms;
    rise_n = rise_n + 1;
    ts = nxt(ts, tms);
  end

  always @(negedge tck)
    tdo_model <= (ts == SHD) ? (has_id ? dr[0] : bp) : 1'b1;

  assign tdo = force_en ? force_val : tdo_model;

  // port monitors, sampled away from the active edge
  logic tck_q = 1'b0, tms_q = 1'b1, have_prev = 1'b0;
  int   iv_cnt = 0, iv_bad = 0, tms_hi_bad = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (tck !== tck_q) begin
      if (have_prev && iv_cnt != int'(half) + 1) iv_bad = iv_bad + 1;
      have_prev = 1'b1;
      iv_cnt = 1;
    end else begin
      iv_cnt = iv_cnt + 1;
    end
    if (tms !== tms_q && tck !== 1'b0) tms_hi_bad = tms_hi_bad + 1;
    tck_q = tck;
    tms_q = tms;
    if (cyc > 190000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog act=%0d exp<190000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_tms(int k);
    return (k < 5) || (k == 6) || (k == 40);
  endfunction

  // kind: 0 device with identifier, 1 bypass only, 2 TDO stuck 0, 3 TDO stuck 1
  task automatic run_case(input int div, input int kind, input logic [31:0] id,
                          input int init, input bit extra);
    logic [31:0] ew;
    logic [31:0] held;
    int t;
    int mism;
    half = 8'(div);
    ts = tap_t'(init % 16);
    dev_id = id;
    has_id = (kind == 0);
    force_en = (kind >= 2);
    force_val = (kind == 3);
    rise_n = 0;
    have_prev = 1'b0;
    iv_bad = 0;
    tms_hi_bad = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", {31'b0, busy}, 32'd1);
    if (extra) begin
      repeat (23) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    t = 0;
    while (res_valid !== 1'b1 && t < 5000) begin
      @(negedge clk);
      t = t + 1;
    end
    chk(res_valid === 1'b1, "R10 result arrives", {31'b0, res_valid}, 32'd1);
    chk(busy === 1'b0, "R10 busy low with valid", {31'b0, busy}, 32'd0);
    case (kind)
      0: ew = id;
      1: ew = 32'hFFFF_FFFE;
      2: ew = 32'h0;
      default: ew = 32'hFFFF_FFFF;
    endcase
    chk(res_word === ew, "R6 R11 word", res_word, ew);
    chk(res_is_id === (ew[0] && ew != 32'hFFFF_FFFF), "R7 is_id",
        {31'b0, res_is_id}, {31'b0, ew[0] && ew != 32'hFFFF_FFFF});
    chk(res_bypass === (!ew[0] && ew != 32'h0), "R8 bypass",
        {31'b0, res_bypass}, {31'b0, !ew[0] && ew != 32'h0});
    chk(res_stuck === (ew == 32'h0 || ew == 32'hFFFF_FFFF), "R9 stuck",
        {31'b0, res_stuck}, {31'b0, ew == 32'h0 || ew == 32'hFFFF_FFFF});
    chk(rise_n == 41, "R5 R2 rising edge count", 32'(rise_n), 32'd41);
    mism = 0;
    for (int k = 0; k < 41 && k < 64; k++)
      if (tms_log[k] !== exp_tms(k)) mism = mism + 1;
    chk(mism == 0, "R5 TMS sequence mismatches", 32'(mism), 32'd0);
    chk(iv_bad == 0, "R3 TCK phase length errors", 32'(iv_bad), 32'd0);
    chk(tms_hi_bad == 0, "R4 TMS change with TCK high", 32'(tms_hi_bad), 32'd0);
    chk(tdi === 1'b1, "R4 TDI level", {31'b0, tdi}, 32'd1);
    if (extra) begin
      held = res_word;
      repeat (6) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (4) @(negedge clk);
      chk(res_valid === 1'b1, "R10 valid held without ready", {31'b0, res_valid}, 32'd1);
      chk(res_word === held, "R10 word held", res_word, held);
      chk(busy === 1'b0, "R2 start ignored while result waits", {31'b0, busy}, 32'd0);
      chk(tck === 1'b0, "R3 TCK idle low", {31'b0, tck}, 32'd0);
    end
    res_ready = 1'b1;
    @(negedge clk) res_ready = 1'b0;
    chk(res_valid === 1'b0, "R10 valid cleared by ready", {31'b0, res_valid}, 32'd0);
  endtask

  initial begin
    logic [31:0] pat;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tck === 1'b0, "R1 tck reset", {31'b0, tck}, 32'd0);
    chk(tms === 1'b1, "R1 tms reset", {31'b0, tms}, 32'd1);
    chk(busy === 1'b0, "R1 busy reset", {31'b0, busy}, 32'd0);
    chk(res_valid === 1'b0, "R1 valid reset", {31'b0, res_valid}, 32'd0);
    for (int d = 0; d < 4; d++) begin
      for (int p = 0; p < 7; p++) begin
        case (p)
          0: pat = 32'h4BA0_0477;
          1: pat = ((32'(d * 7 + 3)) * 32'h9E37_79B9) | 32'h1;
          2: pat = 32'h0000_0001;
          3: pat = 32'hFFFF_FFFF;
          default: pat = 32'h8000_0001;
        endcase
        run_case(d, (p < 4) ? 0 : p - 3, pat, d * 7 + p, (p == 1));
      end
    end
    run_case(0, 0, 32'h8000_0001, 11, 1'b0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule